// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Bank

This block turns a set of external signals into interrupt requests and event pulses. It has 23 independent lines. Each line can be set to fire on a rising edge, a falling edge or on both edges. A detected edge sets a per-line pending flag, and that flag stays set until software clears it. Each line has its own interrupt mask, which gates the pending flag onto a level request. A separate event mask produces a one-cycle pulse on the cycle in which a detection is recorded.

The low 16 lines take their input from a port multiplexer. Line `i` carries pin `i` of whichever of several general-purpose ports its selector picks. The upper lines have dedicated inputs. Each line first catches its edge in a flop clocked by the line itself. This catches pulses that are narrower than one system clock period. The captured flag then passes through a two-stage synchronizer before it updates the pending register. After that, the capture flop is cleared.

A flat register port of word writes and combinational reads holds the masks, the edge enables, the pending flags and the port selectors.

Top module: `xirq_bank`

## Requirements
- R1: After reset, every register reads 0, and the `irq` and `evt` outputs are 0.
- R2: With the rising enable set for a line, a 0-to-1 transition on that line sets its pending bit. The bit becomes visible on the third rising clock edge after the transition.
- R3: With only the falling enable set, a 1-to-0 transition sets the pending bit with the same latency as R2. A 0-to-1 transition does not set it.
- R4: With both enables set, each transition in either direction sets the pending bit. Transitions must be at least 8 clocks apart.
- R5: A high pulse 3 ns wide, shorter than the 20 ns clock, is recorded as exactly one detection. That detection gives one pending set and at most one event pulse.
- R6: Writing the pending register (address 4) clears each bit that is written as 1. Bits written as 0 keep their value.
- R7: If a detection and a clear of the same pending bit land on the same clock edge, the bit stays set.
- R8: `irq[i]` equals pending bit `i` AND interrupt mask bit `i`. `evt[i]` is high for exactly one cycle on the edge where line `i` records a detection, if event mask bit `i` is set.
- R9: A line with neither its rising nor its falling enable set never sets its pending bit, whatever its input does.
- R10: Line `i` for i<16 follows `gpio_in[sel_i*16+i]`, where `sel_i` is bits [2i+1:2i] of the selector register (address 5). Pins of ports that are not selected have no effect on the line.
- R11: Line 16+j is driven by `aux_in[j]`.
- R12: The register addresses are: 0 interrupt mask, 1 event mask, 2 rising enables, 3 falling enables, 4 pending, 5 port selectors. Each register reads back what was written to it, except pending, which follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gpio_in | input | 64 | Pins of 4 ports; port p, pin n is at index p*16+n |
| aux_in | input | 7 | Dedicated inputs for lines 16 to 22 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 23 | Per-line interrupt request |
| evt | output | 23 | Per-line one-cycle event pulse |

## Verification
The line inputs are driven in several ways:
- Sub-period high pulses show that asynchronous capture works where sampling would miss the edge.
- Slow single steps in one direction separate the rising-only, falling-only and both-edge settings.
- Stimulus on non-selected port pins, and on lines with both enables clear, tells a real ignore apart from a missing multiplexer or enable path.
- A clear write placed on the exact edge of a detection separates set-priority from clear-priority.

A behavioural model with per-line countdowns predicts the pending state, `irq` and `evt` on every cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned LINES_DEF = 23;
  localparam int unsigned MUXED_DEF = 16;
  localparam int unsigned PORTS_DEF = 4;
  localparam int unsigned AW        = 3;
  localparam int unsigned DW        = 32;

  typedef enum logic [AW-1:0] {
    A_IMASK = 3'd0,
    A_EMASK = 3'd1,
    A_RISE  = 3'd2,
    A_FALL  = 3'd3,
    A_PEND  = 3'd4,
    A_PSEL  = 3'd5
  } xirq_addr_e;
endpackage

// File: rtl/xirq_port_mux.sv
module xirq_port_mux #(
  parameter int unsigned LINES = 23,
  parameter int unsigned MUXED = 16,
  parameter int unsigned PORTS = 4,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic [PORTS*MUXED-1:0] gpio_in,
  input  logic [LINES-MUXED-1:0] aux_in,
  input  logic [MUXED*SEL_W-1:0] sel_flat,
  output logic [LINES-1:0]       line_vec
);
  for (genvar i = 0; i < MUXED; i++) begin : g_mux
    logic [SEL_W-1:0] sel;
    logic [PORTS-1:0] column;
    assign sel = sel_flat[i*SEL_W +: SEL_W];
    for (genvar p = 0; p < PORTS; p++) begin : g_col
      assign column[p] = gpio_in[p*MUXED + i];
    end
    always_comb begin
      line_vec[i] = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
        if (sel == SEL_W'(p)) line_vec[i] = column[p];
      end
    end
  end
  for (genvar j = MUXED; j < LINES; j++) begin : g_direct
    assign line_vec[j] = aux_in[j-MUXED];
  end
endmodule

// File: rtl/xirq_line_capture.sv
module xirq_line_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic det
);
  logic cap_r, cap_f, hit;
  logic s1_q, s2_q, s3_q;
  logic s1_d, s2_d, s3_d;
  logic clr_n;

  // capture flops hold until the synchronized copy reaches stage two
  assign clr_n = rst_n & ~s2_q;

  always_ff @(posedge line_in or negedge clr_n) begin
    if (!clr_n)       cap_r <= 1'b0;
    else if (rise_en) cap_r <= 1'b1;
  end

  always_ff @(negedge line_in or negedge clr_n) begin
    if (!clr_n)       cap_f <= 1'b0;
    else if (fall_en) cap_f <= 1'b1;
  end

  assign hit = cap_r | cap_f;

  always_comb begin
    s1_d = hit;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign det = s2_q & ~s3_q;

  // one captured edge yields one detection cycle
  p_det_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> !det);
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned LINES = 23,
  parameter int unsigned MUXED = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [LINES-1:0]       det,
  output logic [LINES-1:0]       rise_en,
  output logic [LINES-1:0]       fall_en,
  output logic [MUXED*SEL_W-1:0] sel_flat,
  output logic [DW-1:0]          rdata,
  output logic [LINES-1:0]       irq,
  output logic [LINES-1:0]       evt
);
  localparam int unsigned PSW = MUXED*SEL_W;

  logic [LINES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, evt_q;
  logic [LINES-1:0] pend_d, evt_d, clr;
  logic [PSW-1:0]   psel_q;
  logic imask_en, emask_en, rise_en_w, fall_en_w, psel_en;

  always_comb begin
    imask_en  = we && (addr == A_IMASK);
    emask_en  = we && (addr == A_EMASK);
    rise_en_w = we && (addr == A_RISE);
    fall_en_w = we && (addr == A_FALL);
    psel_en   = we && (addr == A_PSEL);
    clr       = (we && (addr == A_PEND)) ? wdata[LINES-1:0] : '0;
    pend_d    = (pend_q & ~clr) | det;
    evt_d     = det & emask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      psel_q  <= '0;
      pend_q  <= '0;
      evt_q   <= '0;
    end else begin
      if (imask_en)  imask_q <= wdata[LINES-1:0];
      if (emask_en)  emask_q <= wdata[LINES-1:0];
      if (rise_en_w) rise_q  <= wdata[LINES-1:0];
      if (fall_en_w) fall_q  <= wdata[LINES-1:0];
      if (psel_en)   psel_q  <= wdata[PSW-1:0];
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    case (addr)
      A_IMASK: rdata = DW'(imask_q);
      A_EMASK: rdata = DW'(emask_q);
      A_RISE:  rdata = DW'(rise_q);
      A_FALL:  rdata = DW'(fall_q);
      A_PEND:  rdata = DW'(pend_q);
      A_PSEL:  rdata = DW'(psel_q);
      default: rdata = '0;
    endcase
  end

  assign rise_en  = rise_q;
  assign fall_en  = fall_q;
  assign sel_flat = psel_q;
  assign irq      = pend_q & imask_q;
  assign evt      = evt_q;

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R6: a pending bit only drops under a write-one clear
    p_w1c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !(we && addr == A_PEND && wdata[i])) |=> pend_q[i]);
    // R7: a detection always leaves the bit set, clear or not
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      det[i] |=> pend_q[i]);
    // R8: an event pulse coincides with a recorded pending bit
    p_evt_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q[i] |-> pend_q[i]);
  end
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
  import xirq_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter int unsigned MUXED = MUXED_DEF,
  parameter int unsigned PORTS = PORTS_DEF,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS*MUXED-1:0] gpio_in,
  input  logic [LINES-MUXED-1:0] aux_in,
  input  logic                   reg_we,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic [LINES-1:0]       irq,
  output logic [LINES-1:0]       evt
);
  logic rst_meta_q, rst_sync_n;
  logic [LINES-1:0] line_vec, det, rise_en, fall_en;
  logic [MUXED*SEL_W-1:0] sel_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  xirq_port_mux #(.LINES(LINES), .MUXED(MUXED), .PORTS(PORTS)) u_mux (
    .gpio_in  (gpio_in),
    .aux_in   (aux_in),
    .sel_flat (sel_flat),
    .line_vec (line_vec)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    xirq_line_capture u_cap (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .line_in (line_vec[i]),
      .rise_en (rise_en[i]),
      .fall_en (fall_en[i]),
      .det     (det[i])
    );
    // R9: nothing is recorded on a line with both enables clear
    p_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!rise_en[i] && !fall_en[i] && !g_line[i].u_cap.hit) |=> ##1 !det[i]);
  end

  xirq_regs #(.LINES(LINES), .MUXED(MUXED), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .det      (det),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .sel_flat (sel_flat),
    .rdata    (reg_rdata),
    .irq      (irq),
    .evt      (evt)
  );
endmodule

// File: tb/tb_xirq_bank.sv
module tb_xirq_bank;
  localparam int L = 23;
  localparam int M = 16;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P*M-1:0] gpio_in = '0;
  logic [L-M-1:0] aux_in = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [L-1:0] irq, evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xirq_bank dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .aux_in(aux_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .evt(evt)
  );

  always #10 clk = ~clk;

  // reference model
  logic [L-1:0] m_im = '0, m_em = '0, m_rise = '0, m_fall = '0, m_pend = '0, m_evt = '0;
  logic [31:0]  m_psel = '0;
  int cnt [L];

  initial for (int l = 0; l < L; l++) cnt[l] = 0;

  always @(posedge clk) begin
    logic [L-1:0] set, clr;
    set = '0;
    clr = '0;
    for (int l = 0; l < L; l++) begin
      if (cnt[l] > 0) begin
        cnt[l] = cnt[l] - 1;
        if (cnt[l] == 0) set[l] = 1'b1;
      end
    end
    if (rst_n && reg_we) begin
      case (reg_addr)
        3'd0: m_im   = reg_wdata[L-1:0];
        3'd1: m_em   = reg_wdata[L-1:0];
        3'd2: m_rise = reg_wdata[L-1:0];
        3'd3: m_fall = reg_wdata[L-1:0];
        3'd4: clr    = reg_wdata[L-1:0];
        3'd5: m_psel = reg_wdata;
        default: ;
      endcase
    end
    m_evt  = set & m_em;
    m_pend = (m_pend & ~clr) | set;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8: outputs compared with the model every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 irq", 32'(irq), 32'(m_pend & m_im));
      check("R8 evt", 32'(evt), 32'(m_evt));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int line_of_pin(int port, int pin);
    if (pin < M && int'(m_psel[2*pin +: 2]) == port) return pin;
    return -1;
  endfunction

  // narrow high pulse on a port pin
  task automatic gpio_pulse(int port, int pin);
    int ln;
    @(negedge clk);
    #2;
    ln = line_of_pin(port, pin);
    gpio_in[port*M+pin] = 1'b1;
    if (ln >= 0 && (m_rise[ln] || m_fall[ln])) cnt[ln] = 3;
    #3 gpio_in[port*M+pin] = 1'b0;
  endtask

  task automatic aux_step(int j, logic v);
    @(negedge clk);
    aux_in[j] = v;
    if ((v && m_rise[M+j]) || (!v && m_fall[M+j])) cnt[M+j] = 3;
  endtask

  task automatic gpio_step(int port, int pin, logic v);
    int ln;
    @(negedge clk);
    ln = line_of_pin(port, pin);
    gpio_in[port*M+pin] = v;
    if (ln >= 0 && ((v && m_rise[ln]) || (!v && m_fall[ln]))) cnt[ln] = 3;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 and R12: reset contents
    for (int a = 0; a < 6; a++) rd(a, 32'h0, "R1 reset reg");
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 evt", 32'(evt), 32'h0);

    // R12: register map readback
    wr(0, 32'h7FFFFF);
    wr(1, 32'h7FFFFF);
    wr(2, 32'h7FFFFF);
    wr(3, 32'h0);
    wr(5, 32'h0);
    rd(0, 32'h7FFFFF, "R12 imask");
    rd(1, 32'h7FFFFF, "R12 emask");
    rd(2, 32'h7FFFFF, "R12 rise");
    rd(3, 32'h0, "R12 fall");

    // R5 and R2: narrow pulse, rising only
    gpio_pulse(0, 3);
    idle(8);
    rd(4, 32'h8, "R5 narrow pulse R2 rise");

    // R6: writing 0 keeps the bit, writing 1 clears it
    wr(4, 32'h0);
    rd(4, 32'h8, "R6 zero write keeps");
    wr(4, 32'h8);
    rd(4, 32'h0, "R6 one write clears");

    // R3: falling only on line 5
    wr(2, 32'h0);
    wr(3, 32'h20);
    gpio_step(0, 5, 1'b1);
    idle(8);
    rd(4, 32'h0, "R3 rise ignored");
    gpio_step(0, 5, 1'b0);
    idle(8);
    rd(4, 32'h20, "R3 fall sets");
    wr(4, 32'h20);

    // R4 and R11: both edges on aux line 18
    wr(2, 32'h7FFFFF);
    wr(3, 32'h7FFFFF);
    aux_step(2, 1'b1);
    idle(8);
    rd(4, 32'h40000, "R4 R11 rise");
    wr(4, 32'h40000);
    aux_step(2, 1'b0);
    idle(8);
    rd(4, 32'h40000, "R4 R11 fall");
    wr(4, 32'h40000);

    // R9: no enables, nothing recorded
    wr(2, 32'h0);
    wr(3, 32'h0);
    gpio_pulse(0, 7);
    idle(8);
    aux_step(0, 1'b1);
    idle(8);
    aux_step(0, 1'b0);
    idle(8);
    rd(4, 32'h0, "R9 disabled lines");

    // R10: port selection on line 2
    wr(2, 32'h7FFFFF);
    wr(5, 32'h20);
    rd(5, 32'h20, "R12 psel");
    gpio_pulse(0, 2);
    idle(8);
    gpio_pulse(1, 2);
    idle(8);
    rd(4, 32'h0, "R10 unselected port ignored");
    gpio_pulse(2, 2);
    idle(8);
    rd(4, 32'h4, "R10 selected port");
    wr(4, 32'h4);

    // R7: clear on the same edge as the detection
    gpio_pulse(0, 9);
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h200;
    @(negedge clk);
    reg_we = 1'b0;
    idle(4);
    rd(4, 32'h200, "R7 set wins");
    wr(4, 32'h200);
    rd(4, 32'h0, "R7 later clear");

    // R8: masks gate irq and evt
    wr(0, 32'h0);
    wr(1, 32'h0);
    gpio_pulse(0, 11);
    idle(8);
    check("R8 irq masked", 32'(irq), 32'h0);
    check("R8 evt masked", 32'(evt), 32'h0);
    wr(0, 32'h800);
    idle(1);
    check("R8 irq unmasked", 32'(irq), 32'h800);
    wr(4, 32'h800);
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule